// File: doc/BRIEF.md
# Parallel NOR Flash Program/Erase Sequencer

This block sits on the host side of an 8-bit parallel NOR flash bus and turns a single request into the full command protocol the flash expects. A request names an operation (write one byte, erase the sectors selected by an 8-bit mask, or erase the whole device) together with an address and a data byte. The sequencer produces the unlock and command write cycles with the chip-enable, write-enable and output-enable strobes spaced in whole clock cycles. It then polls the flash with read cycles until the embedded operation reports completion, and answers the requester with a one-cycle done pulse and an error flag.

Erasing several sectors is batched into one operation. After the common five-write preamble, one sector-erase write follows per selected sector, lowest index first. The writes run back to back so that every one of them falls inside the flash's short acceptance window. Completion is found by comparing polled status bit 7 with its expected value. A status read that shows the time-limit bit causes one confirming re-read. If that re-read still fails, a reset command is written and an error is reported.

Strobe widths are given in nanoseconds together with the clock period, and the block rounds each of them up to whole cycles.

Top module: `nor_cmd_sequencer`

## Requirements
- R1: Out of reset, `req_ready` is 1, `done` and `err` are 0, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are 1, and `fl_dq_oe` is 0.
- R2: Every bus write holds `fl_ce_n` low and `fl_oe_n` high while `fl_we_n` is low, drives `fl_dq_oe`, and keeps `fl_addr` and `fl_dq_out` unchanged from the cycle before the WE falling edge until after its rising edge.
- R3: Op code 0 (byte program) writes, in order, (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0xA0) and then (req_addr, req_data). Unlock addresses are truncated to the address width.
- R4: Op code 2 (chip erase) writes (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x80), (0x5555, 0xAA), (0x2AAA, 0x55) and then (0x5555, 0x10).
- R5: Op code 1 (sector erase) writes the same five-write preamble as R4 and then one 0x30 write per set bit of `req_mask`, in ascending bit order. Mask bit i uses address i << (AW-3). Between two consecutive writes of one command sequence, WE stays high for no more than WHI+2 cycles.
- R6: A request with op code 1 and an all-zero mask, or with op code 3, completes with `done` and `err` both 1 and produces no bus cycle.
- R7: After the last command write, the block polls with reads at the poll address: req_addr for a program, the lowest selected sector address for a sector erase, and 0 for a chip erase. The operation succeeds when read bit 7 equals the expected value, which is req_data[7] for a program and 1 for an erase. A mismatching read with bit 5 = 0 is followed by another poll.
- R8: A mismatching poll with bit 5 = 1 is followed by exactly one re-read. If that re-read matches, the operation ends without error.
- R9: If the re-read also mismatches, the block writes 0xF0 to the poll address and then ends with `err` = 1.
- R10: `req_ready` is high only while no operation is in progress. `done` lasts exactly one cycle per accepted request, and `err` is only ever high together with `done`.
- R11: The WE low time is max(ceil(WE_LOW_NS/CLK_NS), ceil(ADDR_HOLD_NS/CLK_NS) - WHI) cycles, which is 4 at defaults. The WE high time between writes is at least WHI = ceil(WE_HIGH_NS/CLK_NS) cycles, which is 3 at defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and accepting a request |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 invalid |
| req_addr | input | AW | Byte address for a program |
| req_data | input | 8 | Byte to program |
| req_mask | input | 8 | Sector selection for sector erase, bit i = sector i |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag, valid with done |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Output enable for the data pads |
| fl_dq_in | input | 8 | Data read from the flash |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |

## Verification
Several properties hold on every cycle and are checked continuously: the strobe relationship during a write, address stability while WE is low, the minimum WE low width, the single-cycle done pulse, err appearing only with done, a quiet bus while the block is idle, and the immediate launch of the next sector-erase write. The exact order and content of the command writes, the choice of poll address, the number of polls, the single re-read and the trailing reset write all depend on what the flash answers. Only the bench's scenarios can show these: a bench flash model returns a chosen number of busy reads, a recovered timeout, or a hard timeout, and the logged bus cycles are compared with sequences that the bench computes.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_NONE = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CMD,
        SQ_CMDW,
        SQ_POLLW,
        SQ_REREADW,
        SQ_RSTW,
        SQ_FIN
    } seq_st_e;

    typedef enum logic [2:0] {
        BE_IDLE,
        BE_SET,
        BE_LOW,
        BE_HIGH,
        BE_READ
    } bus_st_e;

    localparam logic [7:0] CMD_UNLOCK1  = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK2  = 8'h55;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_ERASE    = 8'h80;
    localparam logic [7:0] CMD_CHIP     = 8'h10;
    localparam logic [7:0] CMD_SECTOR   = 8'h30;
    localparam logic [7:0] CMD_RESET    = 8'hF0;

    function automatic int ceil_cycles(int ns, int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic logic [2:0] lowest_set(logic [7:0] m);
        logic [2:0] idx;
        idx = 3'd0;
        for (int i = 7; i >= 0; i--) begin
            if (m[i]) idx = 3'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/nor_bus_engine.sv
module nor_bus_engine
    import nor_seq_pkg::*;
#(
    parameter int AW      = 17,
    parameter int WLO_CYC = 4,
    parameter int WHI_CYC = 3,
    parameter int RD_CYC  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_read,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic          busy,
    output logic          done,
    output logic [7:0]    rdata,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [7:0]    fl_dq_in,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);

    localparam int MAXC = (WLO_CYC > WHI_CYC) ?
                          ((WLO_CYC > RD_CYC) ? WLO_CYC : RD_CYC) :
                          ((WHI_CYC > RD_CYC) ? WHI_CYC : RD_CYC);
    localparam int CW = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LO_LAST = CW'(WLO_CYC - 1);
    localparam logic [CW-1:0] HI_LAST = CW'(WHI_CYC - 1);
    localparam logic [CW-1:0] RD_LAST = CW'(RD_CYC - 1);

    typedef struct packed {
        bus_st_e       st;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [7:0]    wdata;
        logic          done;
        logic [7:0]    rdata;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        unique case (eng_q.st)
            BE_IDLE: begin
                if (start) begin
                    eng_d.st    = is_read ? BE_READ : BE_SET;
                    eng_d.addr  = addr;
                    eng_d.wdata = wdata;
                    eng_d.cnt   = '0;
                end
            end
            BE_SET: begin
                eng_d.st  = BE_LOW;
                eng_d.cnt = '0;
            end
            BE_LOW: begin
                if (eng_q.cnt == LO_LAST) begin
                    eng_d.st  = BE_HIGH;
                    eng_d.cnt = '0;
                end else begin
                    eng_d.cnt = eng_q.cnt + 1'b1;
                end
            end
            BE_HIGH: begin
                if (eng_q.cnt == HI_LAST) begin
                    eng_d.st   = BE_IDLE;
                    eng_d.done = 1'b1;
                end else begin
                    eng_d.cnt = eng_q.cnt + 1'b1;
                end
            end
            BE_READ: begin
                if (eng_q.cnt == RD_LAST) begin
                    eng_d.st    = BE_IDLE;
                    eng_d.done  = 1'b1;
                    eng_d.rdata = fl_dq_in;
                end else begin
                    eng_d.cnt = eng_q.cnt + 1'b1;
                end
            end
            default: eng_d.st = BE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: BE_IDLE, cnt: '0, addr: '0, wdata: '0,
                       done: 1'b0, rdata: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign busy      = (eng_q.st != BE_IDLE);
    assign done      = eng_q.done;
    assign rdata     = eng_q.rdata;
    assign fl_addr   = eng_q.addr;
    assign fl_dq_out = eng_q.wdata;
    assign fl_dq_oe  = (eng_q.st == BE_SET) || (eng_q.st == BE_LOW) || (eng_q.st == BE_HIGH);
    assign fl_ce_n   = (eng_q.st == BE_IDLE);
    assign fl_we_n   = (eng_q.st != BE_LOW);
    assign fl_oe_n   = (eng_q.st != BE_READ);

    // Length of the current WE low run, observed at the pins.
    logic [7:0] we_low_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) we_low_run_q <= '0;
        else if (!fl_we_n) we_low_run_q <= (we_low_run_q == 8'hFF) ? we_low_run_q : we_low_run_q + 1'b1;
        else we_low_run_q <= '0;
    end

    // R2
    we_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> (!fl_ce_n && fl_oe_n && fl_dq_oe));

    // R2
    wr_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n || $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

    // R11
    we_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> (we_low_run_q >= 8'(WLO_CYC)));

endmodule

// File: rtl/nor_cmd_sequencer.sv
module nor_cmd_sequencer
    import nor_seq_pkg::*;
#(
    parameter int AW           = 17,
    parameter int CLK_NS       = 8,
    parameter int WE_LOW_NS    = 30,
    parameter int WE_HIGH_NS   = 20,
    parameter int ADDR_HOLD_NS = 45,
    parameter int READ_NS      = 60
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    input  logic [7:0]    req_mask,
    output logic          done,
    output logic          err,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [7:0]    fl_dq_in,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);

    localparam int WLO_BASE = ceil_cycles(WE_LOW_NS, CLK_NS);
    localparam int WHI_CYC  = ceil_cycles(WE_HIGH_NS, CLK_NS);
    localparam int AH_CYC   = ceil_cycles(ADDR_HOLD_NS, CLK_NS);
    localparam int WLO_CYC  = ((AH_CYC - WHI_CYC) > WLO_BASE) ? (AH_CYC - WHI_CYC) : WLO_BASE;
    localparam int RD_RAW   = ceil_cycles(READ_NS, CLK_NS);
    localparam int RD_CYC   = (RD_RAW < 1) ? 1 : RD_RAW;
    localparam int SB       = AW - 3;
    localparam logic [AW-1:0] UA1 = AW'(32'h5555);
    localparam logic [AW-1:0] UA2 = AW'(32'h2AAA);
    localparam logic [2:0] LAST_PRE = 3'd5;

    typedef struct packed {
        seq_st_e       st;
        op_e           op;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic [7:0]    pend;
        logic [2:0]    step;
        logic [AW-1:0] poll_addr;
        logic          err;
    } seq_t;

    seq_t seq_d, seq_q;

    logic          eng_start, eng_rd, eng_busy, eng_done;
    logic [AW-1:0] eng_addr;
    logic [7:0]    eng_wd, eng_rdata;

    function automatic logic [AW-1:0] sector_base(logic [2:0] idx);
        logic [AW-1:0] a;
        a = '0;
        a[AW-1:SB] = idx;
        return a;
    endfunction

    // One command write of a sequence: {address, data}.
    function automatic logic [AW+7:0] seq_word(op_e op, logic [2:0] step,
                                               logic [AW-1:0] a, logic [7:0] d,
                                               logic [7:0] mask);
        logic [AW+7:0] w;
        unique case (step)
            3'd0: w = {UA1, CMD_UNLOCK1};
            3'd1: w = {UA2, CMD_UNLOCK2};
            3'd2: w = (op == OP_PROG) ? {UA1, CMD_PROGRAM} : {UA1, CMD_ERASE};
            3'd3: w = (op == OP_PROG) ? {a, d} : {UA1, CMD_UNLOCK1};
            3'd4: w = {UA2, CMD_UNLOCK2};
            default: w = (op == OP_CHIP) ? {UA1, CMD_CHIP}
                                         : {sector_base(lowest_set(mask)), CMD_SECTOR};
        endcase
        return w;
    endfunction

    logic       exp_b7;
    logic       poll_hit;
    logic [7:0] pend_after;
    logic [2:0] step_next;
    logic       seq_last;

    always_comb begin
        exp_b7   = (seq_q.op == OP_PROG) ? seq_q.data[7] : 1'b1;
        poll_hit = (eng_rdata[7] == exp_b7);

        // Advance to the following write of the command sequence.
        pend_after = seq_q.pend;
        step_next  = seq_q.step + 3'd1;
        seq_last   = 1'b0;
        if (seq_q.op == OP_PROG) begin
            seq_last = (seq_q.step == 3'd3);
        end else if (seq_q.op == OP_CHIP) begin
            seq_last = (seq_q.step == LAST_PRE);
        end else if (seq_q.step == LAST_PRE) begin
            pend_after = seq_q.pend & (seq_q.pend - 8'd1);
            step_next  = LAST_PRE;
            seq_last   = (pend_after == 8'd0);
        end

        seq_d     = seq_q;
        eng_start = 1'b0;
        eng_rd    = 1'b0;
        eng_addr  = '0;
        eng_wd    = '0;

        unique case (seq_q.st)
            SQ_IDLE: begin
                if (req_valid) begin
                    seq_d.op   = op_e'(req_op);
                    seq_d.addr = req_addr;
                    seq_d.data = req_data;
                    seq_d.pend = req_mask;
                    seq_d.step = 3'd0;
                    seq_d.err  = 1'b0;
                    unique case (op_e'(req_op))
                        OP_PROG: seq_d.poll_addr = req_addr;
                        OP_SECT: seq_d.poll_addr = sector_base(lowest_set(req_mask));
                        default: seq_d.poll_addr = '0;
                    endcase
                    if ((op_e'(req_op) == OP_NONE) ||
                        ((op_e'(req_op) == OP_SECT) && (req_mask == 8'd0))) begin
                        seq_d.st  = SQ_FIN;
                        seq_d.err = 1'b1;
                    end else begin
                        seq_d.st = SQ_CMD;
                    end
                end
            end
            SQ_CMD: begin
                eng_start           = 1'b1;
                {eng_addr, eng_wd}  = seq_word(seq_q.op, seq_q.step, seq_q.addr,
                                               seq_q.data, seq_q.pend);
                seq_d.st            = SQ_CMDW;
            end
            SQ_CMDW: begin
                if (eng_done) begin
                    eng_start = 1'b1;
                    if (seq_last) begin
                        eng_rd   = 1'b1;
                        eng_addr = seq_q.poll_addr;
                        seq_d.st = SQ_POLLW;
                    end else begin
                        {eng_addr, eng_wd} = seq_word(seq_q.op, step_next, seq_q.addr,
                                                      seq_q.data, pend_after);
                        seq_d.step = step_next;
                        seq_d.pend = pend_after;
                    end
                end
            end
            SQ_POLLW: begin
                if (eng_done) begin
                    if (poll_hit) begin
                        seq_d.st = SQ_FIN;
                    end else begin
                        eng_start = 1'b1;
                        eng_rd    = 1'b1;
                        eng_addr  = seq_q.poll_addr;
                        if (eng_rdata[5]) seq_d.st = SQ_REREADW;
                    end
                end
            end
            SQ_REREADW: begin
                if (eng_done) begin
                    if (poll_hit) begin
                        seq_d.st = SQ_FIN;
                    end else begin
                        eng_start = 1'b1;
                        eng_addr  = seq_q.poll_addr;
                        eng_wd    = CMD_RESET;
                        seq_d.err = 1'b1;
                        seq_d.st  = SQ_RSTW;
                    end
                end
            end
            SQ_RSTW: begin
                if (eng_done) seq_d.st = SQ_FIN;
            end
            SQ_FIN: begin
                seq_d.st = SQ_IDLE;
            end
            default: seq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SQ_IDLE, op: OP_PROG, addr: '0, data: '0, pend: '0,
                       step: '0, poll_addr: '0, err: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = (seq_q.st == SQ_IDLE);
    assign done      = (seq_q.st == SQ_FIN);
    assign err       = done && seq_q.err;

    nor_bus_engine #(
        .AW      (AW),
        .WLO_CYC (WLO_CYC),
        .WHI_CYC (WHI_CYC),
        .RD_CYC  (RD_CYC)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (eng_start),
        .is_read   (eng_rd),
        .addr      (eng_addr),
        .wdata     (eng_wd),
        .busy      (eng_busy),
        .done      (eng_done),
        .rdata     (eng_rdata),
        .fl_addr   (fl_addr),
        .fl_dq_out (fl_dq_out),
        .fl_dq_oe  (fl_dq_oe),
        .fl_dq_in  (fl_dq_in),
        .fl_ce_n   (fl_ce_n),
        .fl_we_n   (fl_we_n),
        .fl_oe_n   (fl_oe_n)
    );

    // R10
    idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R5
    sector_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == SQ_CMDW && eng_done && seq_q.op == OP_SECT && !seq_last)
        |=> (eng_busy && !fl_ce_n));

    // R6
    reject_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && (req_op == 2'd3)) |=> (done && err && fl_ce_n));

endmodule

// File: tb/nor_cmd_sequencer_test.sv
module nor_cmd_sequencer_test;

    localparam int AW  = 11;
    localparam int WLO = 4;
    localparam int WHI = 3;
    localparam logic [AW-1:0] UA1 = AW'(32'h5555);
    localparam logic [AW-1:0] UA2 = AW'(32'h2AAA);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic [7:0]    req_mask = '0;
    logic          done, err;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_dq_out, fl_dq_in;
    logic          fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

    always #4 clk = ~clk;

    nor_cmd_sequencer #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_mask(req_mask),
        .done(done), .err(err),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
        .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Flash model state
    int         mode = 0;      // 0 busy then ready, 1 timeout then recovered, 2 hard timeout
    int         busy_n = 0;
    logic [7:0] final_val = 8'hFF;
    int         rd_count = 0;
    int         rd_addr_bad = 0;
    logic [AW-1:0] exp_poll = '0;
    logic [AW-1:0] la [32];
    logic [7:0]    ld [32];
    int         wr_n = 0;
    int         shape_bad = 0;
    int         lo_cnt = 0;
    int         lo_min = 1000;
    int         hi_cnt = 0;
    bit         hi_armed = 0;
    int         hi_min = 1000;
    int         hi_max = 0;
    int         ready_bad = 0;
    logic [AW-1:0] lo_addr;
    logic [7:0]    lo_data;
    logic       prev_we = 1'b1;
    logic       prev_oe = 1'b1;

    function automatic logic [7:0] resp(int k);
        logic [7:0] bad_busy, bad_to;
        bad_busy = {~final_val[7], k[0], 6'b0};
        bad_to   = {~final_val[7], 1'b0, 1'b1, 5'b0};
        if (mode == 0) return (k < busy_n) ? bad_busy : final_val;
        if (mode == 1) return (k == 0) ? bad_to : final_val;
        return bad_to;
    endfunction

    assign fl_dq_in = resp(rd_count);

    always @(negedge clk) begin
        if (!fl_we_n) begin
            if (fl_ce_n || !fl_oe_n || !fl_dq_oe) shape_bad++;
            if (prev_we) begin
                lo_addr = fl_addr;
                lo_data = fl_dq_out;
                lo_cnt  = 1;
                if (hi_armed) begin
                    if (hi_cnt < hi_min) hi_min = hi_cnt;
                    if (hi_cnt > hi_max) hi_max = hi_cnt;
                end
                hi_armed = 0;
            end else begin
                lo_cnt++;
                if (fl_addr != lo_addr || fl_dq_out != lo_data) shape_bad++;
            end
        end else if (!prev_we) begin
            if (fl_addr != lo_addr || fl_dq_out != lo_data) shape_bad++;
            if (wr_n < 32) begin
                la[wr_n] = lo_addr;
                ld[wr_n] = lo_data;
            end
            wr_n++;
            if (lo_cnt < lo_min) lo_min = lo_cnt;
            hi_armed = 1;
            hi_cnt = 1;
        end else if (hi_armed) begin
            hi_cnt++;
        end
        if (!fl_oe_n) begin
            hi_armed = 0;
            if (fl_addr != exp_poll) rd_addr_bad++;
        end else if (!prev_oe) begin
            rd_count++;
        end
        if (req_ready && !fl_ce_n) ready_bad++;
        prev_we = fl_we_n;
        prev_oe = fl_oe_n;
    end

    logic [AW-1:0] ea [32];
    logic [7:0]    ed [32];
    int            exp_n;

    function automatic logic [AW-1:0] sect_addr(int i);
        return AW'(i) << (AW - 3);
    endfunction

    task automatic build_expect(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                                input logic [7:0] m);
        exp_n = 0;
        ea[0] = UA1; ed[0] = 8'hAA;
        ea[1] = UA2; ed[1] = 8'h55;
        if (op == 0) begin
            ea[2] = UA1; ed[2] = 8'hA0;
            ea[3] = a;   ed[3] = d;
            exp_n = 4;
            exp_poll = a;
            final_val = d;
        end else begin
            ea[2] = UA1; ed[2] = 8'h80;
            ea[3] = UA1; ed[3] = 8'hAA;
            ea[4] = UA2; ed[4] = 8'h55;
            exp_n = 5;
            final_val = 8'hFF;
            if (op == 2) begin
                ea[5] = UA1; ed[5] = 8'h10;
                exp_n = 6;
                exp_poll = '0;
            end else begin
                exp_poll = '0;
                for (int i = 7; i >= 0; i--) if (m[i]) exp_poll = sect_addr(i);
                for (int i = 0; i < 8; i++) begin
                    if (m[i]) begin
                        ea[exp_n] = sect_addr(i);
                        ed[exp_n] = 8'h30;
                        exp_n++;
                    end
                end
            end
        end
        if (mode == 2) begin
            ea[exp_n] = exp_poll;
            ed[exp_n] = 8'hF0;
            exp_n++;
        end
    endtask

    task automatic run_op(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                          input logic [7:0] m, input int md, input int bn, input string tag);
        int  wait_cyc;
        bit  reject;
        int  exp_rd;
        bit  seq_ok;
        int  first_bad;
        logic err_seen;
        mode = md;
        busy_n = bn;
        reject = (op == 3) || (op == 1 && m == 8'd0);
        build_expect(op, a, d, m);
        if (reject) exp_n = 0;
        @(negedge clk);
        wr_n = 0; rd_count = 0; rd_addr_bad = 0; shape_bad = 0; ready_bad = 0;
        lo_min = 1000; hi_min = 1000; hi_max = 0; hi_armed = 0;
        req_op = 2'(op); req_addr = a; req_data = d; req_mask = m;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_cyc = 0;
        while (!done && wait_cyc < 5000) begin
            @(negedge clk);
            wait_cyc++;
        end
        chk(done == 1'b1, {tag, " R10 done seen"}, done, 1);
        err_seen = err;
        @(negedge clk);
        chk(done == 1'b0, {tag, " R10 done one cycle"}, done, 0);
        chk(ready_bad == 0, {tag, " R10 ready only when idle"}, ready_bad, 0);
        if (reject) begin
            chk(err_seen == 1'b1, {tag, " R6 err on reject"}, err_seen, 1);
            chk(wr_n == 0 && rd_count == 0, {tag, " R6 no bus cycles"}, wr_n + rd_count, 0);
            return;
        end
        exp_rd = (md == 0) ? bn + 1 : 2;
        chk(err_seen == (md == 2), {tag, " R8/R9 error flag"}, err_seen, (md == 2));
        chk(wr_n == exp_n, {tag, " R3/R4/R5 write count"}, wr_n, exp_n);
        seq_ok = 1; first_bad = 0;
        for (int i = 0; i < exp_n && i < wr_n && i < 32; i++) begin
            if (seq_ok && (la[i] != ea[i] || ld[i] != ed[i])) begin
                seq_ok = 0;
                first_bad = i;
            end
        end
        chk(seq_ok, {tag, (op == 0) ? " R3 program writes" : (op == 2) ? " R4 chip writes" : " R5 sector writes"},
            {la[first_bad], ld[first_bad]}, {ea[first_bad], ed[first_bad]});
        if (md == 2)
            chk(la[exp_n-1] == exp_poll && ld[exp_n-1] == 8'hF0, {tag, " R9 reset write"},
                {la[exp_n-1], ld[exp_n-1]}, {exp_poll, 8'hF0});
        chk(rd_count == exp_rd, {tag, (md == 0) ? " R7 poll count" : " R8 single reread"}, rd_count, exp_rd);
        chk(rd_addr_bad == 0, {tag, " R7 poll address"}, rd_addr_bad, 0);
        chk(shape_bad == 0, {tag, " R2 write strobe shape"}, shape_bad, 0);
        chk(lo_min >= WLO, {tag, " R11 WE low width"}, lo_min, WLO);
        chk(hi_min >= WHI, {tag, " R11 WE high width"}, hi_min, WHI);
        chk(hi_max <= WHI + 2, {tag, " R5 no stall between writes"}, hi_max, WHI + 2);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(done == 1'b0 && err == 1'b0, "R1 done/err low", {done, err}, 0);
        chk(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R1 bus idle",
            {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}, 4'b1110);

        // Directed corner cases
        run_op(0, 11'h123, 8'h80, 8'h00, 0, 0, "prog b7=1 ready");
        run_op(0, 11'h7FF, 8'h35, 8'h00, 0, 3, "prog b7=0 busy");
        run_op(2, 11'h000, 8'h00, 8'h00, 0, 2, "chip erase");
        run_op(1, 11'h000, 8'h00, 8'hA5, 0, 1, "sectors A5");
        run_op(1, 11'h000, 8'h00, 8'h80, 0, 0, "sector 7 only");
        run_op(1, 11'h000, 8'h00, 8'hFF, 0, 0, "all sectors");
        run_op(1, 11'h000, 8'h00, 8'h00, 0, 0, "R6 empty mask");
        run_op(3, 11'h000, 8'h00, 8'h00, 0, 0, "R6 bad op");
        run_op(0, 11'h2AA, 8'hC3, 8'h00, 1, 0, "R8 prog recovered");
        run_op(0, 11'h055, 8'h11, 8'h00, 2, 0, "R9 prog timeout");
        run_op(1, 11'h000, 8'h00, 8'h12, 2, 0, "R9 sector timeout");

        // Constrained random mix
        for (int it = 0; it < 40; it++) begin
            int op, md, bn;
            logic [7:0] m;
            op = int'($urandom % 3);
            md = int'($urandom % 3);
            bn = int'($urandom % 5);
            m  = 8'($urandom);
            if (m == 8'd0) m = 8'h01;
            run_op(op, AW'($urandom), 8'($urandom), m, md, bn, $sformatf("rand%0d", it));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule